// File: doc/BRIEF.md
# Load/Store Byte Lane Steering Unit

This unit sits between a 32-bit register datapath and a byte-addressable memory data bus that is 32 bits wide. Each transfer carries a direction (store or load), a size (byte, half-word or word), a signedness flag, a byte-order select and the access address. Only the low two address bits matter to the unit.

On a store, the unit places the register value onto the bus lanes and raises the byte enables for the lanes that are written. On a load, it takes the addressed bytes from the bus word, moves them to the low end of the result, and fills the upper bits with zeros or with copies of the sign bit. Byte order is chosen per transfer. A word or half-word whose address is not a multiple of its size is flagged as an alignment fault, and that transfer writes no lanes.

Transfers enter and leave through a valid/ready pair. A parameter decides whether results pass straight through or are held in one output register. With the register in place, `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A result waits in the register, unchanged, until `out_ready` accepts it. With the register removed, ready and valid pass through the unit unchanged.

Top module: `lsu_lane_unit`

## Requirements
- R1: A byte store (size code 0) copies the low byte of `in_wdata` to all four lanes. It raises exactly one enable: lane k in little-endian mode or lane 3-k in big-endian mode, where k is the address offset. Lane k is bits 8k+7:8k.
- R2: A half-word store (size code 1) at offset 0 or 2 copies the low 16 bits of `in_wdata` to both halves. The enables are 4'b0011 for little-endian offset 0 and for big-endian offset 2. They are 4'b1100 for little-endian offset 2 and for big-endian offset 0.
- R3: A word store (size code 2) at offset 0 drives `in_wdata` unchanged with enables 4'b1111, in either byte order.
- R4: A byte load returns the byte on lane k (little-endian) or lane 3-k (big-endian) in bits 7:0. The result is zero-extended when `in_signed` is 0 and sign-extended when it is 1.
- R5: A half-word load at offset 0 or 2 returns bits 15:0 (little-endian offset 0, big-endian offset 2) or bits 31:16 (little-endian offset 2, big-endian offset 0) of `in_rdata` in its low 16 bits. The result is zero- or sign-extended according to `in_signed`.
- R6: A word load at offset 0 returns `in_rdata` unchanged, whatever the values of `in_signed` and `in_big_end`.
- R7: For a load, `out_be` is 4'b0000 and the value of `in_wdata` has no effect. For a store, `out_ldata` is zero.
- R8: A half-word at an odd offset, a word at a nonzero offset, or the reserved size code 3 raises `out_fault`. It forces `out_be` and `out_ldata` to zero. A byte access never faults.
- R9: Address bits above bit 1 have no effect on any output.
- R10: With `REG_OUT`=1, `out_valid` is 0 from reset. A transfer accepted at a clock edge appears on the outputs right after that edge.
- R11: With `REG_OUT`=1, while `out_valid` is high and `out_ready` is low, `in_ready` is low and every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Transfer request present |
| in_ready | output | 1 | Unit can take a transfer |
| in_store | input | 1 | 1 = store, 0 = load |
| in_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| in_signed | input | 1 | Sign-extend narrow loads |
| in_big_end | input | 1 | 1 = big-endian byte order |
| in_addr | input | ADDR_W | Access byte address |
| in_wdata | input | DATA_W | Register value to store |
| in_rdata | input | DATA_W | Bus word returned for a load |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_wdata | output | DATA_W | Lane-steered store data |
| out_be | output | DATA_W/8 | Store byte enables |
| out_ldata | output | DATA_W | Aligned, extended load result |
| out_fault | output | 1 | Misaligned or reserved-size access |

## Verification
The bench sweeps every combination of direction, size code, signedness, byte order and offset. It uses data patterns with the top bit of each byte set and clear, and address upper bits that change from one transfer to the next. A lane-mapping error that mirrors the big-endian offset shows up as the wrong enable or the wrong byte. A missing or misplaced sign fill shows up as upper bits that differ between the two `in_signed` values. The fault check covers odd half-word offsets, every nonzero word offset and the reserved size. A design that let enables through on a fault, or leaked load data on a store, fails those checks. A stall sequence holds `out_ready` low while a second transfer waits. A register that overwrote its held result, or kept `in_ready` high, would lose the first transfer.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic [1:0] {
    XFER_BYTE = 2'd0,
    XFER_HALF = 2'd1,
    XFER_WORD = 2'd2,
    XFER_RSVD = 2'd3
  } xfer_size_e;
endpackage

// File: rtl/lane_align_check.sv
module lane_align_check
  import lsu_lane_pkg::*;
#(
  parameter int unsigned OFS_W = 2
) (
  input  xfer_size_e       size,
  input  logic [OFS_W-1:0] ofs,
  output logic             fault
);
  always_comb begin
    unique case (size)
      XFER_BYTE: fault = 1'b0;
      XFER_HALF: fault = ofs[0];
      XFER_WORD: fault = (ofs != '0);
      default:   fault = 1'b1;
    endcase
  end
endmodule

// File: rtl/lane_store_steer.sv
module lane_store_steer
  import lsu_lane_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                       is_store,
  input  xfer_size_e                 size,
  input  logic                       big_end,
  input  logic [$clog2(DATA_W/8)-1:0] ofs,
  input  logic                       fault,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          wbus,
  output logic [DATA_W/8-1:0]        be
);
  localparam int unsigned LANES  = DATA_W / LANE_W;
  localparam int unsigned OFS_W  = $clog2(LANES);
  localparam int unsigned HALVES = LANES / 2;
  localparam int unsigned HS_W   = OFS_W - 1;

  logic [OFS_W-1:0] byte_lane;
  logic [HS_W-1:0]  half_slot;
  logic [HS_W-1:0]  half_idx;

  assign half_idx  = ofs[OFS_W-1:1];
  assign byte_lane = big_end ? (OFS_W'(LANES - 1) - ofs) : ofs;
  assign half_slot = big_end ? (HS_W'(HALVES - 1) - half_idx) : half_idx;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic byte_hit;
    logic half_hit;
    assign byte_hit = (byte_lane == OFS_W'(i));
    assign half_hit = (half_slot == HS_W'(i / 2));

    always_comb begin
      unique case (size)
        XFER_BYTE: wbus[LANE_W*i +: LANE_W] = wdata[LANE_W-1:0];
        XFER_HALF: wbus[LANE_W*i +: LANE_W] = wdata[LANE_W*(i % 2) +: LANE_W];
        default:   wbus[LANE_W*i +: LANE_W] = wdata[LANE_W*i +: LANE_W];
      endcase
    end

    always_comb begin
      be[i] = 1'b0;
      if (is_store && !fault) begin
        unique case (size)
          XFER_BYTE: be[i] = byte_hit;
          XFER_HALF: be[i] = half_hit;
          XFER_WORD: be[i] = 1'b1;
          default:   be[i] = 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/lane_load_extract.sv
module lane_load_extract
  import lsu_lane_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                        is_load,
  input  xfer_size_e                  size,
  input  logic                        sign_ext,
  input  logic                        big_end,
  input  logic [$clog2(DATA_W/8)-1:0] ofs,
  input  logic                        fault,
  input  logic [DATA_W-1:0]           rdata,
  output logic [DATA_W-1:0]           ldata
);
  localparam int unsigned LANES  = DATA_W / LANE_W;
  localparam int unsigned OFS_W  = $clog2(LANES);
  localparam int unsigned HALVES = LANES / 2;
  localparam int unsigned HS_W   = OFS_W - 1;
  localparam int unsigned HALF_W = 2 * LANE_W;

  logic [OFS_W-1:0]  byte_lane;
  logic [HS_W-1:0]   half_slot;
  logic [HS_W-1:0]   half_idx;
  logic [LANE_W-1:0] byte_pick;
  logic [HALF_W-1:0] half_pick;

  assign half_idx  = ofs[OFS_W-1:1];
  assign byte_lane = big_end ? (OFS_W'(LANES - 1) - ofs) : ofs;
  assign half_slot = big_end ? (HS_W'(HALVES - 1) - half_idx) : half_idx;

  always_comb begin
    byte_pick = '0;
    for (int i = 0; i < LANES; i++) begin
      if (byte_lane == OFS_W'(i)) byte_pick = rdata[LANE_W*i +: LANE_W];
    end
  end

  always_comb begin
    half_pick = '0;
    for (int i = 0; i < HALVES; i++) begin
      if (half_slot == HS_W'(i)) half_pick = rdata[HALF_W*i +: HALF_W];
    end
  end

  always_comb begin
    ldata = '0;
    if (is_load && !fault) begin
      unique case (size)
        XFER_BYTE: ldata = {{(DATA_W-LANE_W){sign_ext & byte_pick[LANE_W-1]}}, byte_pick};
        XFER_HALF: ldata = {{(DATA_W-HALF_W){sign_ext & half_pick[HALF_W-1]}}, half_pick};
        XFER_WORD: ldata = rdata;
        default:   ldata = '0;
      endcase
    end
  end
endmodule

// File: rtl/lane_out_stage.sv
module lane_out_stage #(
  parameter int unsigned PAY_W   = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PAY_W-1:0] in_pay,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PAY_W-1:0] out_pay
);
  if (REG_OUT) begin : g_reg
    logic             vld_q;
    logic [PAY_W-1:0] pay_q;

    assign in_ready  = !vld_q || out_ready;
    assign out_valid = vld_q;
    assign out_pay   = pay_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        pay_q <= '0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) pay_q <= in_pay;
      end
    end
  end else begin : g_pass
    logic unused_clk;
    assign unused_clk = clk ^ rst_n;
    assign in_ready   = out_ready;
    assign out_valid  = in_valid;
    assign out_pay    = in_pay;
  end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_lane_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_store,
  input  logic [1:0]          in_size,
  input  logic                in_signed,
  input  logic                in_big_end,
  input  logic [ADDR_W-1:0]   in_addr,
  input  logic [DATA_W-1:0]   in_wdata,
  input  logic [DATA_W-1:0]   in_rdata,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_wdata,
  output logic [DATA_W/8-1:0] out_be,
  output logic [DATA_W-1:0]   out_ldata,
  output logic                out_fault
);
  localparam int unsigned LANES = DATA_W / LANE_W;
  localparam int unsigned OFS_W = $clog2(LANES);
  localparam int unsigned PAY_W = 2 * DATA_W + LANES + 1;

  xfer_size_e        size;
  logic [OFS_W-1:0]  ofs;
  logic              fault;
  logic [DATA_W-1:0] wbus;
  logic [LANES-1:0]  be;
  logic [DATA_W-1:0] ldata;
  logic [PAY_W-1:0]  pay_in;
  logic [PAY_W-1:0]  pay_out;
  logic              unused_addr_hi;

  assign size           = xfer_size_e'(in_size);
  assign ofs            = in_addr[OFS_W-1:0];
  assign unused_addr_hi = ^in_addr[ADDR_W-1:OFS_W];

  lane_align_check #(.OFS_W(OFS_W)) u_align (
    .size  (size),
    .ofs   (ofs),
    .fault (fault)
  );

  lane_store_steer #(.DATA_W(DATA_W)) u_store (
    .is_store (in_store),
    .size     (size),
    .big_end  (in_big_end),
    .ofs      (ofs),
    .fault    (fault),
    .wdata    (in_wdata),
    .wbus     (wbus),
    .be       (be)
  );

  lane_load_extract #(.DATA_W(DATA_W)) u_load (
    .is_load  (!in_store),
    .size     (size),
    .sign_ext (in_signed),
    .big_end  (in_big_end),
    .ofs      (ofs),
    .fault    (fault),
    .rdata    (in_rdata),
    .ldata    (ldata)
  );

  assign pay_in = {wbus, be, ldata, fault};

  lane_out_stage #(.PAY_W(PAY_W), .REG_OUT(REG_OUT)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_pay    (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pay   (pay_out)
  );

  assign {out_wdata, out_be, out_ldata, out_fault} = pay_out;
endmodule

// File: rtl/lsu_lane_checker.sv
module lsu_lane_checker #(
  parameter int unsigned DATA_W  = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [DATA_W-1:0]   out_wdata,
  input logic [DATA_W/8-1:0] out_be,
  input logic [DATA_W-1:0]   out_ldata,
  input logic                out_fault
);
  assert_fault_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fault |-> (out_be == '0) && (out_ldata == '0));

  assert_be_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_be) <= 2) || (out_be == '1));

  assert_stall_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  if (REG_OUT) begin : g_reg_props
    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_wdata) && $stable(out_be)
        && $stable(out_ldata) && $stable(out_fault));

    assert_valid_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid && in_ready));
  end
endmodule

bind lsu_lane_unit lsu_lane_checker #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_wdata (out_wdata),
  .out_be    (out_be),
  .out_ldata (out_ldata),
  .out_fault (out_fault)
);

// File: tb/test_lsu_lane_unit.sv
module test_lsu_lane_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_store = 1'b0;
  logic [1:0]  in_size = 2'd0;
  logic        in_signed = 1'b0;
  logic        in_big_end = 1'b0;
  logic [31:0] in_addr = '0;
  logic [31:0] in_wdata = '0;
  logic [31:0] in_rdata = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_wdata;
  logic [3:0]  out_be;
  logic [31:0] out_ldata;
  logic        out_fault;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lsu_lane_unit #(.DATA_W(32), .ADDR_W(32), .REG_OUT(1'b1)) i_lsu_lane_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_store(in_store), .in_size(in_size), .in_signed(in_signed),
    .in_big_end(in_big_end), .in_addr(in_addr), .in_wdata(in_wdata),
    .in_rdata(in_rdata), .out_valid(out_valid), .out_ready(out_ready),
    .out_wdata(out_wdata), .out_be(out_be), .out_ldata(out_ldata),
    .out_fault(out_fault)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic expf(input logic [1:0] sz, input int ofs);
    return (sz == 2'd3) || (sz == 2'd1 && (ofs % 2) == 1) || (sz == 2'd2 && ofs != 0);
  endfunction

  function automatic logic [31:0] expw(input logic [1:0] sz, input logic [31:0] wd);
    if (sz == 2'd0) return {4{wd[7:0]}};
    if (sz == 2'd1) return {2{wd[15:0]}};
    return wd;
  endfunction

  function automatic logic [3:0] expbe(input logic st, input logic [1:0] sz, input logic big, input int ofs);
    if (!st || expf(sz, ofs)) return 4'b0000;
    if (sz == 2'd0) return 4'(1 << (big ? 3 - ofs : ofs));
    if (sz == 2'd1) return big ? (4'b1100 >> ofs) : (4'b0011 << ofs);
    return 4'b1111;
  endfunction

  function automatic logic [31:0] expl(input logic st, input logic [1:0] sz, input logic sg,
                                       input logic big, input int ofs, input logic [31:0] rd);
    logic [31:0] v;
    if (st || expf(sz, ofs)) return 32'h0;
    if (sz == 2'd0) begin
      v = (rd >> (8 * (big ? 3 - ofs : ofs))) & 32'hFF;
      if (sg && v >= 32'h80) v = v - 32'h100;
      return v;
    end
    if (sz == 2'd1) begin
      v = (rd >> (8 * (big ? 2 - ofs : ofs))) & 32'hFFFF;
      if (sg && v >= 32'h8000) v = v - 32'h10000;
      return v;
    end
    return rd;
  endfunction

  function automatic string tag(input logic st, input logic [1:0] sz, input int ofs);
    if (expf(sz, ofs)) return "R8";
    if (st) return (sz == 2'd0) ? "R1" : (sz == 2'd1) ? "R2" : "R3";
    return (sz == 2'd0) ? "R4" : (sz == 2'd1) ? "R5" : "R6";
  endfunction

  task automatic drive(input logic st, input logic [1:0] sz, input logic sg, input logic big,
                       input logic [31:0] addr, input logic [31:0] wd, input logic [31:0] rd);
    in_valid = 1'b1; in_store = st; in_size = sz; in_signed = sg;
    in_big_end = big; in_addr = addr; in_wdata = wd; in_rdata = rd;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] pats [3];
    pats[0] = 32'h8A4C_F17E;
    pats[1] = 32'h7F80_01FE;
    pats[2] = 32'hC3B5_2796;

    repeat (3) @(negedge clk);
    chk("R10 reset out_valid", 32'(out_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle out_valid", 32'(out_valid), 32'h0);

    for (int p = 0; p < 3; p++)
      for (int big = 0; big < 2; big++)
        for (int st = 0; st < 2; st++)
          for (int sz = 0; sz < 4; sz++)
            for (int sg = 0; sg < 2; sg++)
              for (int ofs = 0; ofs < 4; ofs++) begin
                logic [31:0] wd;
                logic [31:0] rd;
                logic [31:0] addr;
                string t;
                wd   = pats[p] ^ {16'h0, 8'(ofs * 37), 8'(sz * 11)};
                rd   = pats[(p + 1) % 3] ^ {8'(ofs * 29), 24'h0};
                addr = {8'(p * 97 + ofs), 8'(sz * 53), 8'(big * 201), 6'(st * 17 + sg), 2'(ofs)};
                t    = tag(st[0], sz[1:0], ofs);
                drive(st[0], sz[1:0], sg[0], big[0], addr, wd, rd);
                @(negedge clk);
                chk({t, " R10 valid"}, 32'(out_valid), 32'h1);
                chk({t, " fault R8"}, 32'(out_fault), 32'(expf(sz[1:0], ofs)));
                chk({t, " be R7 R9"}, 32'(out_be), 32'(expbe(st[0], sz[1:0], big[0], ofs)));
                chk({t, " ldata R7 R9"}, out_ldata, expl(st[0], sz[1:0], sg[0], big[0], ofs, rd));
                if (st == 1) chk({t, " wdata R9"}, out_wdata, expw(sz[1:0], wd));
              end

    // R11 back-pressure: A held while B waits
    drive(1'b0, 2'd0, 1'b1, 1'b0, 32'h0000_0001, 32'h0, 32'h0000_9A00);
    @(negedge clk);
    chk("R4 stall A ldata", out_ldata, 32'hFFFF_FF9A);
    out_ready = 1'b0;
    drive(1'b1, 2'd2, 1'b0, 1'b1, 32'h0000_0000, 32'h1234_5678, 32'h0);
    #1;
    chk("R11 in_ready low", 32'(in_ready), 32'h0);
    @(negedge clk);
    chk("R11 hold valid", 32'(out_valid), 32'h1);
    chk("R11 hold ldata", out_ldata, 32'hFFFF_FF9A);
    chk("R11 hold be", 32'(out_be), 32'h0);
    out_ready = 1'b1;
    #1;
    chk("R11 in_ready back", 32'(in_ready), 32'h1);
    @(negedge clk);
    chk("R3 after stall be", 32'(out_be), 32'hF);
    chk("R3 after stall wdata", out_wdata, 32'h1234_5678);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10 drain valid", 32'(out_valid), 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule